// File: doc/BRIEF.md
# Vector Double-to-Single Narrowing Converter

This unit narrows a pair of IEEE-754 double-precision values into single precision for a vector register file. It decodes a 32-bit instruction word. When the word is the narrowing conversion, the two 64-bit lanes of the 128-bit source vector are rounded to 32-bit values, using the rounding mode given on the `rmode_i` pin. The two results form one 64-bit pair, and that pair goes into either the low half or the high half of the 128-bit destination.

The caller supplies the destination's current contents on `dst_old_i`, so the untouched half can be carried through. The narrowed pair is written low when the instruction's q bit is 0, and the upper 64 bits are then zeroed. When q is 1 the pair is written high and the low half keeps the old value. The unit handles only the double-to-single form. The single-to-half form (s bit 0) and every non-matching word are flagged as not handled, and the destination value passes through unchanged.

All outputs are registered, with one cycle from inputs to outputs. The register indices taken from the instruction are also brought out, so that the caller can route the write-back.

Top module: `fcvtn_unit`

## Requirements
- R1: `legal_o` is 1 exactly when the instruction has bit 31 = 0, bits 29..23 = 0011100, bits 21..10 = 100001011010 and bit 22 (s) = 1.
- R2: When `legal_o` would be 0 (a non-matching word, or s = 0), `dst_new_o` equals the `dst_old_i` of the same cycle.
- R3: Source bits 63..0 convert into 32-bit destination lane 2q and source bits 127..64 into lane 2q+1, with lane k at bits 32k+31..32k and q = instruction bit 30.
- R4: With q = 0, destination bits 127..64 are zero.
- R5: With q = 1, destination bits 63..0 equal `dst_old_i[63:0]`.
- R6: Rounding mode 00 rounds to the nearest single value, and exact ties go to the value with an even mantissa.
- R7: Rounding modes 01, 10 and 11 round toward +infinity, toward -infinity and toward zero respectively. An inexact result never lands on the value on the excluded side.
- R8: A finite value whose magnitude exceeds the single range becomes signed infinity if the mode rounds away from zero for that sign, and the largest finite single of that sign otherwise.
- R9: A value below the smallest normal single becomes a correctly rounded single denormal or signed zero, in the active mode.
- R10: A NaN input gives sign, exponent all ones, quiet bit 22 = 1 and bits 21..0 = input bits 50..29. Infinity stays infinity and signed zero stays signed zero.
- R11: All outputs change one clock edge after their inputs. While `rst_n` is low at an edge, they are all cleared to zero.
- R12: `src_idx_o` and `dst_idx_o` carry instruction bits 9..5 and 4..0 from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| insn_i | input | 32 | Instruction word |
| src_vec_i | input | 128 | Source vector, two double lanes |
| dst_old_i | input | 128 | Current destination contents |
| rmode_i | input | 2 | Rounding mode: 00 nearest-even, 01 up, 10 down, 11 toward zero |
| dst_new_o | output | 128 | New destination contents |
| legal_o | output | 1 | Instruction recognised and handled |
| src_idx_o | output | 5 | Source register index |
| dst_idx_o | output | 5 | Destination register index |

## Verification
Two things happen in the same cycle: the rounding of both lanes, and the zeroing or keeping of the destination half that is not written. They interact when a rounding increment carries into the exponent or overflows to infinity. The bench provokes this with mantissas of all ones and exact-halfway patterns near the top and bottom of the single range. It combines these with q = 1 and a random old destination. The whole 128-bit result is compared with a model that finds the correctly rounded single by bisection over real values, a method independent of the shift-and-sticky datapath.

// File: rtl/fcvtn_pkg.sv
// fcvtn_pkg: formats and rounding-mode encoding shared by the narrowing unit.
// Assumes IEEE-754 binary64 input lanes and binary32 results.
package fcvtn_pkg;
    localparam int DBL_W     = 64;
    localparam int DBL_EXP_W = 11;
    localparam int DBL_MAN_W = 52;
    localparam int SGL_W     = 32;
    localparam int SGL_EXP_W = 8;
    localparam int SGL_MAN_W = 23;
    localparam int LANES     = 2;
    localparam int VEC_W     = DBL_W * LANES;
    localparam int HALF_W    = VEC_W / 2;
    localparam int REG_IDX_W = 5;
    // rebias offset between formats (1023 - 127)
    localparam int REBIAS    = 896;
    // bits dropped from the mantissa for a normal result
    localparam int DROP      = DBL_MAN_W - SGL_MAN_W;

    typedef enum logic [1:0] {
        RND_NEAREST = 2'b00,
        RND_UP      = 2'b01,
        RND_DOWN    = 2'b10,
        RND_ZERO    = 2'b11
    } rnd_mode_e;
endpackage

// File: rtl/fcvtn_decode.sv
// fcvtn_decode: recognises the vector narrowing-conversion word and extracts
// its fields. Purely combinational; assumes a 32-bit instruction.
module fcvtn_decode
    import fcvtn_pkg::*;
(
    input  logic [31:0]          insn_i,
    output logic                 match_o,
    output logic                 legal_o,
    output logic                 q_o,
    output logic [REG_IDX_W-1:0] rn_o,
    output logic [REG_IDX_W-1:0] rd_o
);
    localparam logic [6:0]  MAJOR_OP = 7'b0011100;
    localparam logic [11:0] MINOR_OP = 12'b1000_0101_1010;

    // field match and the supported-size qualifier
    always_comb begin
        match_o = (insn_i[31] == 1'b0) && (insn_i[29:23] == MAJOR_OP)
                  && (insn_i[21:10] == MINOR_OP);
        legal_o = match_o && insn_i[22];
        q_o     = insn_i[30];
        rn_o    = insn_i[9:5];
        rd_o    = insn_i[4:0];
    end
endmodule

// File: rtl/fcvtn_lane_cvt.sv
// fcvtn_lane_cvt: converts one binary64 value to binary32 under a dynamic
// rounding mode. Normal and subnormal results share one shift/guard/sticky
// path; rounding is an increment of the packed exponent:mantissa field so a
// mantissa carry moves into the exponent by itself. Combinational.
module fcvtn_lane_cvt
    import fcvtn_pkg::*;
(
    input  logic [DBL_W-1:0] dbl_i,
    input  rnd_mode_e        rmode_i,
    output logic [SGL_W-1:0] sgl_o
);
    localparam logic [DBL_EXP_W-1:0] DEXP_MAX = '1;
    localparam logic [SGL_W-2:0]     MAG_INF  = 31'h7F80_0000;
    localparam logic [SGL_W-2:0]     MAG_MAXF = 31'h7F7F_FFFF;

    logic                       sgn;
    logic [DBL_EXP_W-1:0]       dexp;
    logic [DBL_MAN_W-1:0]       dman;
    logic signed [12:0]         sexp;
    logic [63:0]                sig64;
    logic [5:0]                 shamt;
    logic [SGL_MAN_W-1:0]       kept;
    logic [SGL_EXP_W-1:0]       exp_f;
    logic                       guard, sticky, inc, away;
    logic [SGL_W-2:0]           mag_trunc;
    logic [SGL_W-1:0]           mag_rnd;
    logic                       ovf;

    // shift, round and classify one lane
    always_comb begin
        sgn   = dbl_i[DBL_W-1];
        dexp  = dbl_i[DBL_W-2 -: DBL_EXP_W];
        dman  = dbl_i[DBL_MAN_W-1:0];
        sig64 = {11'b0, (dexp != '0), dman};
        sexp  = $signed({2'b00, dexp}) - 13'sd896;
        if (sexp >= 13'sd1)        shamt = 6'(DROP);
        else if (sexp < -13'sd33)  shamt = 6'd63;
        else                       shamt = 6'(13'sd30 - sexp);
        kept   = 23'(sig64 >> shamt);
        guard  = sig64[shamt - 6'd1];
        sticky = |(sig64 & ((64'd1 << (shamt - 6'd1)) - 64'd1));
        exp_f  = (sexp >= 13'sd1) ? sexp[7:0] : 8'd0;
        mag_trunc = {exp_f, kept};
        away   = (rmode_i == RND_UP && !sgn) || (rmode_i == RND_DOWN && sgn);
        case (rmode_i)
            RND_NEAREST: inc = guard && (sticky || mag_trunc[0]);
            RND_UP,
            RND_DOWN:    inc = away && (guard || sticky);
            default:     inc = 1'b0;
        endcase
        mag_rnd = {1'b0, mag_trunc} + {31'b0, inc};
        ovf     = (sexp > 13'sd254) || (mag_rnd[30:23] == 8'hFF);

        if (dexp == DEXP_MAX)
            sgl_o = (dman != '0) ? {sgn, 8'hFF, 1'b1, dman[50:29]}
                                 : {sgn, MAG_INF};
        else if (ovf)
            sgl_o = {sgn, (rmode_i == RND_NEAREST || away) ? MAG_INF : MAG_MAXF};
        else
            sgl_o = {sgn, mag_rnd[30:0]};

        // R10
        nan_only_from_nan_chk: assert ((dexp == DEXP_MAX && dman != '0)
            || !(sgl_o[30:23] == 8'hFF && sgl_o[22:0] != '0));
    end
endmodule

// File: rtl/fcvtn_unit.sv
// fcvtn_unit: vector double-to-single narrowing. Decodes the instruction,
// converts both source lanes, places the pair in the low (q=0, high half
// cleared) or high (q=1, low half kept) half, and registers the result.
// Assumes the caller supplies the destination's current value on dst_old_i.
module fcvtn_unit
    import fcvtn_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [31:0]          insn_i,
    input  logic [VEC_W-1:0]     src_vec_i,
    input  logic [VEC_W-1:0]     dst_old_i,
    input  logic [1:0]           rmode_i,
    output logic [VEC_W-1:0]     dst_new_o,
    output logic                 legal_o,
    output logic [REG_IDX_W-1:0] src_idx_o,
    output logic [REG_IDX_W-1:0] dst_idx_o
);
    logic                 dec_match, dec_legal, dec_q;
    logic [REG_IDX_W-1:0] dec_rn, dec_rd;
    logic [SGL_W-1:0]     cvt [LANES];
    logic [HALF_W-1:0]    pair;
    logic [VEC_W-1:0]     dst_next;

    fcvtn_decode u_decode (
        .insn_i  (insn_i),
        .match_o (dec_match),
        .legal_o (dec_legal),
        .q_o     (dec_q),
        .rn_o    (dec_rn),
        .rd_o    (dec_rd)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fcvtn_lane_cvt u_cvt (
            .dbl_i   (src_vec_i[g*DBL_W +: DBL_W]),
            .rmode_i (rnd_mode_e'(rmode_i)),
            .sgl_o   (cvt[g])
        );
    end

    // pack converted lanes and place them in the destination
    always_comb begin
        pair = {cvt[1], cvt[0]};
        if (!dec_legal)
            dst_next = dst_old_i;
        else if (dec_q)
            dst_next = {pair, dst_old_i[HALF_W-1:0]};
        else
            dst_next = {{HALF_W{1'b0}}, pair};
    end

    // output register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_new_o <= '0;
            legal_o   <= 1'b0;
            src_idx_o <= '0;
            dst_idx_o <= '0;
        end else begin
            dst_new_o <= dst_next;
            legal_o   <= dec_legal;
            src_idx_o <= dec_rn;
            dst_idx_o <= dec_rd;
        end
    end

    // R4
    upper_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_legal && !dec_q) |=> (dst_new_o[VEC_W-1:HALF_W] == '0));
    // R5
    lower_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_legal && dec_q) |=> (dst_new_o[HALF_W-1:0] == $past(dst_old_i[HALF_W-1:0])));
    // R2
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_legal) |=> (!legal_o && dst_new_o == $past(dst_old_i)));
    // R7
    rz_no_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_legal && !dec_q && rmode_i == 2'b11 && src_vec_i[62:52] != 11'h7FF)
        |=> (dst_new_o[30:23] != 8'hFF));
    // R10
    nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_legal && !dec_q && src_vec_i[62:52] == 11'h7FF && src_vec_i[51:0] != '0)
        |=> (dst_new_o[30:22] == 9'h1FF));
endmodule

// File: tb/test_fcvtn_unit.sv
// test_fcvtn_unit: directed corners plus seeded random vectors, compared
// with a bisection-based rounding model computed in real arithmetic.
module test_fcvtn_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  insn = '0;
    logic [127:0] src = '0;
    logic [127:0] old = '0;
    logic [1:0]   rm = '0;
    logic [127:0] dst_new;
    logic         legal;
    logic [4:0]   src_idx, dst_idx;
    int           n_tests = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    fcvtn_unit i_fcvtn_unit (
        .clk(clk), .rst_n(rst_n), .insn_i(insn), .src_vec_i(src),
        .dst_old_i(old), .rmode_i(rm), .dst_new_o(dst_new), .legal_o(legal),
        .src_idx_o(src_idx), .dst_idx_o(dst_idx)
    );

    function automatic logic [31:0] mk_insn(bit q, bit s, logic [4:0] rn, logic [4:0] rd);
        return {1'b0, q, 7'b0011100, s, 12'b100001011010, rn, rd};
    endfunction

    function automatic real p2(int k);
        real r = 1.0;
        if (k >= 0) repeat (k) r = r * 2.0;
        else repeat (-k) r = r / 2.0;
        return r;
    endfunction

    function automatic real sgl_val(logic [30:0] m);
        int e = int'(m[30:23]);
        real f = real'(int'(m[22:0]));
        if (e == 0) return f * p2(-149);
        return (1.0 + f / 8388608.0) * p2(e - 127);
    endfunction

    // reference: largest single not above |x| by bisection, then round
    function automatic logic [31:0] ref_cvt(logic [63:0] d, logic [1:0] mode);
        real a, tv, ulp, midv;
        longint lo, hi, mid;
        logic [30:0] t, res;
        bit exact, neg;
        neg = d[63];
        if (d[62:52] == 11'h7FF)
            return (d[51:0] != 0) ? {neg, 8'hFF, 1'b1, d[50:29]} : {neg, 31'h7F800000};
        a = $bitstoreal({1'b0, d[62:0]});
        lo = 0; hi = 64'h7F7FFFFF;
        while (lo < hi) begin
            mid = (lo + hi + 1) / 2;
            if (sgl_val(31'(mid)) <= a) lo = mid; else hi = mid - 1;
        end
        t = 31'(lo);
        tv = sgl_val(t);
        exact = (tv == a);
        ulp = (t == 31'h7F7FFFFF) ? p2(104) : sgl_val(t + 31'd1) - tv;
        midv = tv + ulp / 2.0;
        if (exact) res = t;
        else case (mode)
            2'b00: res = (a > midv) ? t + 31'd1 : (a < midv) ? t : (t[0] ? t + 31'd1 : t);
            2'b01: res = neg ? t : t + 31'd1;
            2'b10: res = neg ? t + 31'd1 : t;
            default: res = t;
        endcase
        return {neg, res};
    endfunction

    function automatic logic [127:0] ref_vec(logic [31:0] w, logic [127:0] s,
                                             logic [127:0] o, logic [1:0] mode);
        logic [63:0] pr;
        bit ok = (w[31] == 0) && (w[29:23] == 7'b0011100) && (w[21:10] == 12'b100001011010) && w[22];
        if (!ok) return o;
        pr = {ref_cvt(s[127:64], mode), ref_cvt(s[63:0], mode)};
        return w[30] ? {pr, o[63:0]} : {64'b0, pr};
    endfunction

    function automatic logic [63:0] rnd_dbl();
        logic [51:0] m = {20'($urandom), $urandom};
        logic [10:0] e = 11'($urandom);
        case ($urandom % 8)
            0: e = 11'(866 + $urandom % 40);
            1: e = 11'(1148 + $urandom % 6);
            2: e = 11'd0;
            3: e = 11'h7FF;
            4: begin e = 11'(880 + $urandom % 300); m[28:0] = 29'h10000000; end
            5: begin e = 11'(860 + $urandom % 300); m[28:0] = 29'h1FFFFFFF; end
            default: ;
        endcase
        return {1'($urandom), e, m};
    endfunction

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run(string tag, logic [31:0] w, logic [127:0] s,
                       logic [127:0] o, logic [1:0] mode);
        insn = w; src = s; old = o; rm = mode;
        @(negedge clk);
        check(tag, dst_new, ref_vec(w, s, o, mode));
    endtask

    task automatic run1(string tag, logic [63:0] d, logic [1:0] mode, logic [31:0] exp);
        insn = mk_insn(0, 1, 5'd1, 5'd2); src = {64'h0, d}; old = '1; rm = mode;
        @(negedge clk);
        check(tag, {96'b0, dst_new[31:0]}, {96'b0, exp});
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] o;
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        // R11: reset values
        check("R11 reset", {dst_new, 1'b0, legal, src_idx, dst_idx}, '0);
        rst_n = 1'b1;
        o = {4{32'hA5A5_5A5A}};
        // R3 R4: q=0 placement, +1.0 and -2.5
        insn = mk_insn(0, 1, 5'd7, 5'd19); src = {64'hC004000000000000, 64'h3FF0000000000000};
        old = o; rm = 2'b00;
        @(negedge clk);
        check("R3 R4 low placement", dst_new, {64'b0, 32'hC0200000, 32'h3F800000});
        check("R1 legal", {127'b0, legal}, 128'd1);
        check("R12 indices", {118'b0, src_idx, dst_idx}, {118'b0, 5'd7, 5'd19});
        // R11: output follows one edge later
        insn = mk_insn(1, 1, 5'd7, 5'd19);
        #1;
        check("R11 latency hold", dst_new, {64'b0, 32'hC0200000, 32'h3F800000});
        @(negedge clk);
        check("R3 R5 high placement", dst_new, {32'hC0200000, 32'h3F800000, o[63:0]});
        // R2: s=0 and a wrong opcode bit
        run("R2 size s0", mk_insn(1, 0, 5'd1, 5'd1), src, o, 2'b00);
        check("R1 s0 not legal", {127'b0, legal}, 128'd0);
        run("R2 bad opcode", mk_insn(0, 1, 5'd1, 5'd1) ^ 32'h0000_0400, src, ~o, 2'b01);
        // R6: ties to even
        run1("R6 tie even down", 64'h3FF0000010000000, 2'b00, 32'h3F800000);
        run1("R6 tie even up", 64'h3FF0000030000000, 2'b00, 32'h3F800002);
        // R7: directed modes
        run1("R7 up pos", 64'h3FF0000000400000, 2'b01, 32'h3F800001);
        run1("R7 down pos", 64'h3FF0000000400000, 2'b10, 32'h3F800000);
        run1("R7 down neg", 64'hBFF0000000400000, 2'b10, 32'hBF800001);
        run1("R7 zero neg", 64'hBFF0000000400000, 2'b11, 32'hBF800000);
        // R8: overflow
        run1("R8 ovf nearest", 64'h47F0000000000000, 2'b00, 32'h7F800000);
        run1("R8 ovf zero", 64'h47F0000000000000, 2'b11, 32'h7F7FFFFF);
        run1("R8 ovf up neg", 64'hC7F0000000000000, 2'b01, 32'hFF7FFFFF);
        // R9: tiny
        run1("R9 min denormal", 64'h36A0000000000000, 2'b00, 32'h00000001);
        run1("R9 half min nearest", 64'h3690000000000000, 2'b00, 32'h00000000);
        run1("R9 half min up", 64'h3690000000000000, 2'b01, 32'h00000001);
        run1("R9 neg zero", 64'h8000000000000000, 2'b00, 32'h80000000);
        // R10: NaN and infinity
        run1("R10 snan quieted", 64'h7FF0000000000001, 2'b00, 32'h7FC00000);
        run1("R10 payload", 64'hFFF8000020000000, 2'b11, 32'hFFC00001);
        run1("R10 infinity", 64'h7FF0000000000000, 2'b11, 32'h7F800000);
        // random mix covering all requirements R3..R10 and R2
        for (int i = 0; i < 600; i++) begin
            logic [31:0] w = mk_insn(1'($urandom), ($urandom % 8) != 0, 5'($urandom), 5'($urandom));
            if ($urandom % 16 == 0) w = $urandom;
            run("R3-mix random", w, {rnd_dbl(), rnd_dbl()}, {$urandom, $urandom, $urandom, $urandom},
                2'($urandom));
        end
        // R11: reset clears again
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset again", {dst_new, 1'b0, legal, src_idx, dst_idx}, '0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule